// File: doc/BRIEF.md
# USB 2.0 Bus-Idle Suspend Detector

This block watches the USB 2.0 line state of a device port, sampled once per tick of a fixed-rate clock, and reports a 4-bit link state code. A long stretch of bus idle is first reported as an intermediate early-suspend state. The block then confirms either a real suspend or, in high-speed operation, a bus reset from the host. All idle periods (nominally 3 ms each) are parameters counted in sample-clock ticks, so a bench can scale them down.

In high-speed operation the idle level is SE0. SE0 can mean either suspend or reset, so after the early-suspend report the block waits for a pulse saying that the pull-up re-enable delay has finished. It then looks at the line again. A full-speed J means suspend is coming; an SE0 means the host is driving reset. In full-speed operation the idle level is J, and two idle periods in a row lead to suspend with no extra check. An external connect input gates the whole state machine out of the disconnected state.

Top module: `usb2_idle_susp_det`

## Requirements
- R1: After reset `link_state` is 4'h4 (Disconnected) and `reset_det` is 0. The block stays Disconnected while `connect` is 0 and moves to On (4'h0) on the first clock edge that samples `connect` at 1.
- R2: A sample of `connect` at 0 in any state gives Disconnected (4'h4) after that edge, with no reset pulse.
- R3: `line_state` is coded 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 SE1. With `hs_mode`=1 in On, IDLE_TICKS consecutive SE0 samples give Early Suspend (4'h5) on the edge of the last one. Any other sample restarts the count.
- R4: With `hs_mode`=0 in On, IDLE_TICKS consecutive J samples give Early Suspend (4'h5). SE0, K and SE1 restart the count.
- R5: In the high-speed early-suspend wait, the line is checked on the edge that samples `pu_done`=1. J moves on to suspend confirmation. SE0 returns to On and raises `reset_det` for exactly one cycle. K or SE1 returns to On. Before that pulse, a K or SE1 sample returns to On.
- R6: During suspend confirmation, reported as Early Suspend, SUSP_TICKS consecutive J samples give Suspend (4'h3). Any non-J sample returns to On.
- R7: In Suspend, any non-J sample returns the state to On, and the idle count starts again from zero.
- R8: With `hib_en`=1 the early-suspend phases report On (4'h0) instead of 4'h5. Transitions and their timing are unchanged.
- R9: The idle timer saturates at its maximum value and never wraps, so Suspend holds through any length of J idle.
- R10: A `pu_done` pulse outside the high-speed early-suspend wait has no effect on the state or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| connect | input | 1 | Device attached and pull-up enabled |
| hs_mode | input | 1 | 1 = high-speed operation, 0 = full-speed |
| hib_en | input | 1 | Hibernation enabled; hides the early-suspend code |
| pu_done | input | 1 | One-cycle pulse: pull-up re-enable delay finished |
| line_state | input | 2 | Sampled bus line state (SE0, J, K, SE1) |
| link_state | output | 4 | Encoded link state |
| reset_det | output | 1 | One-cycle pulse: bus reset seen at the post-delay check |

## Verification
The hardest situation to reach is the high-speed post-delay check, where the answer depends on the line value on the exact edge that samples `pu_done`. The stimulus holds SE0 for exactly IDLE_TICKS samples, one short of that, and one count broken by a single J. It then pulses `pu_done` while driving SE0, J or K to reach reset detection, confirmation and abort. Saturation is reached by holding J in Suspend for several times the counter range. A reference model in the bench is compared with both outputs on every cycle.

// File: rtl/usb2_isd_pkg.sv
package usb2_isd_pkg;

   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10,
      LN_SE1 = 2'b11
   } line_e;

   typedef enum logic [2:0] {
      PH_DISC,
      PH_ON,
      PH_CHECK,
      PH_CONFIRM,
      PH_SUSP
   } phase_e;

   localparam logic [3:0] LINK_ON    = 4'h0;
   localparam logic [3:0] LINK_SUSP  = 4'h3;
   localparam logic [3:0] LINK_DISC  = 4'h4;
   localparam logic [3:0] LINK_ESUSP = 4'h5;

endpackage

// File: rtl/usb2_isd_timer.sv
module usb2_isd_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/usb2_isd_fsm.sv
module usb2_isd_fsm
   import usb2_isd_pkg::*;
#(
   parameter int IDLE_TICKS = 16,
   parameter int SUSP_TICKS = 16,
   parameter int CNT_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             connect,
   input  logic             hs_mode,
   input  logic             pu_done,
   input  logic [1:0]       line_state,
   input  logic [CNT_W-1:0] cnt,
   output phase_e           phase,
   output logic             tmr_clr,
   output logic             reset_det
);

   localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_TICKS - 1);
   localparam logic [CNT_W-1:0] SUSP_LAST = CNT_W'(SUSP_TICKS - 1);

   line_e  ln;
   logic   ln_j, ln_se0, on_idle, rst_hit;
   phase_e nxt;

   assign ln      = line_e'(line_state);
   assign ln_j    = (ln == LN_J);
   assign ln_se0  = (ln == LN_SE0);
   assign on_idle = hs_mode ? ln_se0 : ln_j;

   always_comb begin
      nxt     = phase;
      tmr_clr = 1'b1;
      rst_hit = 1'b0;
      unique case (phase)
         PH_DISC: if (connect) nxt = PH_ON;
         PH_ON: begin
            if (on_idle) begin
               if (cnt == IDLE_LAST)
                  nxt = hs_mode ? PH_CHECK : PH_CONFIRM;
               else
                  tmr_clr = 1'b0;
            end
         end
         PH_CHECK: begin
            if (pu_done) begin
               if (ln_j) begin
                  nxt = PH_CONFIRM;
               end else begin
                  nxt     = PH_ON;
                  rst_hit = ln_se0;
               end
            end else if (!(ln_se0 || ln_j)) begin
               nxt = PH_ON;
            end
         end
         PH_CONFIRM: begin
            if (!ln_j)
               nxt = PH_ON;
            else if (cnt == SUSP_LAST)
               nxt = PH_SUSP;
            else
               tmr_clr = 1'b0;
         end
         PH_SUSP: begin
            if (ln_j) tmr_clr = 1'b0;
            else      nxt     = PH_ON;
         end
         default: nxt = PH_DISC;
      endcase
      if (!connect) begin
         nxt     = PH_DISC;
         tmr_clr = 1'b1;
         rst_hit = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_DISC;
         reset_det <= 1'b0;
      end else begin
         phase     <= nxt;
         reset_det <= rst_hit;
      end
   end

endmodule

// File: rtl/usb2_isd_enc.sv
module usb2_isd_enc
   import usb2_isd_pkg::*;
(
   input  phase_e     phase,
   input  logic       hib_en,
   output logic [3:0] link_state
);

   always_comb begin
      unique case (phase)
         PH_ON:                link_state = LINK_ON;
         PH_CHECK, PH_CONFIRM: link_state = hib_en ? LINK_ON : LINK_ESUSP;
         PH_SUSP:              link_state = LINK_SUSP;
         default:              link_state = LINK_DISC;
      endcase
   end

endmodule

// File: rtl/usb2_idle_susp_det.sv
module usb2_idle_susp_det
   import usb2_isd_pkg::*;
#(
   parameter int IDLE_TICKS = 180000,
   parameter int SUSP_TICKS = 180000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       connect,
   input  logic       hs_mode,
   input  logic       hib_en,
   input  logic       pu_done,
   input  logic [1:0] line_state,
   output logic [3:0] link_state,
   output logic       reset_det
);

   localparam int MAX_TICKS = (IDLE_TICKS > SUSP_TICKS) ? IDLE_TICKS : SUSP_TICKS;
   localparam int CNT_W     = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS);

   generate
      if (IDLE_TICKS < 2) begin : g_bad_idle
         $error("IDLE_TICKS must be at least 2");
      end
      if (SUSP_TICKS < 2) begin : g_bad_susp
         $error("SUSP_TICKS must be at least 2");
      end
   endgenerate

   phase_e           phase;
   logic             tmr_clr;
   logic [CNT_W-1:0] tmr_cnt;

   usb2_isd_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .cnt_q (tmr_cnt)
   );

   usb2_isd_fsm #(
      .IDLE_TICKS (IDLE_TICKS),
      .SUSP_TICKS (SUSP_TICKS),
      .CNT_W      (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .connect    (connect),
      .hs_mode    (hs_mode),
      .pu_done    (pu_done),
      .line_state (line_state),
      .cnt        (tmr_cnt),
      .phase      (phase),
      .tmr_clr    (tmr_clr),
      .reset_det  (reset_det)
   );

   usb2_isd_enc u_enc (
      .phase      (phase),
      .hib_en     (hib_en),
      .link_state (link_state)
   );

endmodule

// File: rtl/usb2_isd_chk.sv
module usb2_isd_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             connect,
   input logic             hib_en,
   input logic [1:0]       line_state,
   input logic [3:0]       link_state,
   input logic             reset_det,
   input logic [CNT_W-1:0] tmr_cnt
);

   a_r2_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
      !connect |=> (link_state == 4'h4 && !reset_det));

   a_r5_rstdet_single: assert property (@(posedge clk) disable iff (!rst_n)
      reset_det |=> !reset_det);

   a_r5_rstdet_on: assert property (@(posedge clk) disable iff (!rst_n)
      reset_det |-> (link_state == 4'h0));

   a_r6_susp_from_j: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == 4'h3 && !$stable(link_state)) |-> ($past(line_state) == 2'b01));

   a_r7_susp_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == 4'h3 && connect && line_state != 2'b01) |=> (link_state == 4'h0));

   a_r8_hib_mask: assert property (@(posedge clk) disable iff (!rst_n)
      hib_en |-> (link_state != 4'h5));

   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_cnt == '1) |=> (tmr_cnt == '1 || tmr_cnt == '0));

endmodule

bind usb2_idle_susp_det usb2_isd_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .connect    (connect),
   .hib_en     (hib_en),
   .line_state (line_state),
   .link_state (link_state),
   .reset_det  (reset_det),
   .tmr_cnt    (tmr_cnt)
);

// File: tb/tb_usb2_idle_susp_det.sv
module tb_usb2_idle_susp_det;

   localparam int IT = 20;
   localparam int ST = 15;
   localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic connect = 1'b0, hs_mode = 1'b1, hib_en = 1'b0, pu_done = 1'b0;
   logic [1:0] line_state = J;
   logic [3:0] link_state;
   logic reset_det;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   usb2_idle_susp_det #(.IDLE_TICKS(IT), .SUSP_TICKS(ST)) dut (
      .clk(clk), .rst_n(rst_n), .connect(connect), .hs_mode(hs_mode),
      .hib_en(hib_en), .pu_done(pu_done), .line_state(line_state),
      .link_state(link_state), .reset_det(reset_det)
   );

   always #10 clk = ~clk;

   // reference model: 0 disc, 1 on, 2 hs wait, 3 confirm, 4 suspended
   int m_ph = 0;
   int m_run = 0;
   bit m_rd = 1'b0;

   always @(posedge clk) begin
      int np;
      bit keep;
      np = m_ph;
      keep = 1'b0;
      m_rd = 1'b0;
      if (!rst_n) begin
         np = 0;
      end else if (!connect) begin
         np = 0;
      end else if (m_ph == 0) begin
         np = 1;
      end else if (m_ph == 1) begin
         if ((hs_mode && line_state == SE0) || (!hs_mode && line_state == J)) begin
            if (m_run + 1 >= IT) np = hs_mode ? 2 : 3;
            else keep = 1'b1;
         end
      end else if (m_ph == 2) begin
         if (pu_done) begin
            np = (line_state == J) ? 3 : 1;
            m_rd = (line_state == SE0);
         end else if (line_state == K || line_state == SE1) begin
            np = 1;
         end
      end else begin
         if (line_state != J) np = 1;
         else if (m_ph == 3 && m_run + 1 >= ST) np = 4;
         else keep = 1'b1;
      end
      m_run = keep ? m_run + 1 : 0;
      m_ph = np;
   end

   function automatic logic [3:0] exp_link();
      case (m_ph)
         0: return 4'h4;
         1: return 4'h0;
         4: return 4'h3;
         default: return hib_en ? 4'h0 : 4'h5;
      endcase
   endfunction

   function automatic string ph_tag();
      if (hib_en && (m_ph == 2 || m_ph == 3)) return "R8";
      case (m_ph)
         0: return "R1";
         1: return "R3";
         2: return "R5";
         3: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check4(input logic [3:0] act, input logic [3:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: link_state=%h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check1(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: reset_det=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check4(link_state, exp_link(), ph_tag());
         check1(reset_det, m_rd, "R5");
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic to_on();
      connect = 1'b0; line_state = K; step(1);
      connect = 1'b1; step(1);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      check4(link_state, 4'h4, "R1");
      check1(reset_det, 1'b0, "R1");
      rst_n = 1'b1;
      step(5);
      check4(link_state, 4'h4, "R1");
      connect = 1'b1; step(1);
      check4(link_state, 4'h0, "R1");

      // R3: high-speed SE0 count, interrupted once
      hs_mode = 1'b1; line_state = SE0; step(IT - 1);
      check4(link_state, 4'h0, "R3");
      line_state = J; step(1);
      line_state = SE0; step(IT - 1);
      check4(link_state, 4'h0, "R3");
      step(1);
      check4(link_state, 4'h5, "R3");
      // R5: J at the post-delay check, then R6 confirmation
      line_state = J; step(3);
      check4(link_state, 4'h5, "R5");
      pu_done = 1'b1; step(1); pu_done = 1'b0;
      check4(link_state, 4'h5, "R5");
      step(ST - 1);
      check4(link_state, 4'h5, "R6");
      step(1);
      check4(link_state, 4'h3, "R6");
      // R9: long suspend, timer must saturate, state holds
      step(100);
      check4(link_state, 4'h3, "R9");
      pu_done = 1'b1; step(1); pu_done = 1'b0;
      check4(link_state, 4'h3, "R10");
      line_state = K; step(1);
      check4(link_state, 4'h0, "R7");

      // R5: SE0 at the post-delay check means bus reset
      line_state = SE0; step(IT);
      check4(link_state, 4'h5, "R3");
      pu_done = 1'b1; step(1); pu_done = 1'b0;
      check4(link_state, 4'h0, "R5");
      check1(reset_det, 1'b1, "R5");
      step(1);
      check1(reset_det, 1'b0, "R5");
      // R5: K during the wait aborts
      step(IT - 1);
      check4(link_state, 4'h5, "R5");
      line_state = K; step(1);
      check4(link_state, 4'h0, "R5");
      // R5: SE1 at the check aborts without reset pulse
      line_state = SE0; step(IT);
      line_state = SE1; pu_done = 1'b1; step(1); pu_done = 1'b0;
      check4(link_state, 4'h0, "R5");
      check1(reset_det, 1'b0, "R5");

      // R4: full speed J idle, SE0 does not count
      hs_mode = 1'b0; line_state = K; step(1);
      line_state = SE0; step(IT + 2);
      check4(link_state, 4'h0, "R4");
      line_state = J; step(IT - 1);
      check4(link_state, 4'h0, "R4");
      step(1);
      check4(link_state, 4'h5, "R4");
      // R10: pu_done in confirmation is ignored
      pu_done = 1'b1; step(1); pu_done = 1'b0;
      step(ST - 2);
      check4(link_state, 4'h5, "R10");
      step(1);
      check4(link_state, 4'h3, "R6");
      line_state = SE0; step(1);
      check4(link_state, 4'h0, "R7");
      // R6: confirmation broken by K
      line_state = J; step(IT + 5);
      line_state = K; step(1);
      check4(link_state, 4'h0, "R6");

      // R8: hibernation hides the early code, timing unchanged
      hib_en = 1'b1; line_state = J; step(IT);
      check4(link_state, 4'h0, "R8");
      step(ST);
      check4(link_state, 4'h3, "R8");
      hib_en = 1'b0;

      // R2: disconnect from suspend, then from early suspend
      connect = 1'b0; step(1);
      check4(link_state, 4'h4, "R2");
      to_on();
      hs_mode = 1'b1; line_state = SE0; step(IT);
      check4(link_state, 4'h5, "R3");
      connect = 1'b0; pu_done = 1'b1; step(1); pu_done = 1'b0;
      check4(link_state, 4'h4, "R2");
      check1(reset_det, 1'b0, "R2");
      step(2);
      check4(link_state, 4'h4, "R2");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule